// File: doc/BRIEF.md
# Radix-W Population Counter with Staggered Digit Outputs

This block counts how many bits are set in a word of W^K bits. The count comes out as K digits in radix W plus one overflow bit. Each digit is a one-hot W-bit field, and the overflow bit stands for the value W^K. The circuit is made only of rotate chains. Each chain cell either passes a one-hot residue through or rotates it by one place. A cell emits a rotation bit when the residue wraps past W-1. No chain is longer than W*W cells.

The structure is recursive. Level 2 counts W*W raw bits with one long chain. A second, short chain then turns that chain's grouped carry into the next digit. Each higher level joins W counters of the level below, one digit column at a time. Before a sub-counter digit enters a column chain, it is changed from one-hot to thermometer form. The carry from the column below joins it as a sparse vector whose popcount is the carry value. The top column takes the sub-counters' overflow bits plus that carry.

Each chain pass is one register stage. Digit i therefore appears K+i-2 cycles after its sample. The overflow bit appears after 2K-2 cycles. A new word can be accepted on every cycle. A valid flag travels with each digit so that the flag's timing matches the digit's latency.

Top module: `radix_popcount`

## Requirements
- R1: While reset is held and in the first cycle after it, every valid flag and top_o are 0, and every digit field reads value zero (bit 0 set).
- R2: Digit i (i = 1..K) is the field dig_o[(i-1)*W +: W]. The field is one-hot, and bit j set means the value j.
- R3: For a valid sample, the sum of digit_i * W^(i-1) over all i, plus top_o * W^K, equals the number of ones in in_bits.
- R4: dvld_o[i-1] is high exactly K+i-2 cycles after a cycle in which in_valid was high. Digit i holds that sample's digit in that same cycle.
- R5: top_o and dvld_o[K] appear 2K-2 cycles after the sample, in the same cycle as digit K. top_o is 1 only when all bits are set, and then digits K and K-1 read zero.
- R6: Samples accepted on consecutive cycles each produce their own correct digits, even though the outputs of different samples overlap in the same cycle.
- R7: A cycle with in_valid low produces no valid flag on any output, whatever in_bits holds.
- R8: Counts at carry boundaries are correct, such as W-1, W, W^2-1, W^2, W^K-1 and W^K. These include cases where a carry travels through every column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks in_bits as a sample to count |
| in_bits | input | W**K | Word whose ones are counted |
| dig_o | output | K*W | One-hot radix-W digits, least significant digit in the lowest field |
| top_o | output | 1 | Overflow digit; high when the count is W^K |
| dvld_o | output | K+1 | Per-digit valid; bit i-1 for digit i, bit K for top_o |

## Verification
The digit latencies are staggered, so the low digit of a newer sample leaves the block in the same cycle as a higher digit of an older sample. The top column of one word can also be resolving a ripple carry while a lower column already holds the next word. The bench provokes this overlap by issuing back-to-back valid words that alternate between all-ones and all-zeros or near-boundary counts, with invalid gaps mixed in. The bench checks each digit against the sample that the digit's own latency points back to. A digit taken from a neighbouring sample therefore shows up as a miscompare.

// File: rtl/radix_popcount.sv
module radix_popcount #(
  parameter int W = 4,
  parameter int K = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [W**K-1:0]    in_bits,
  output logic [K*W-1:0]     dig_o,
  output logic               top_o,
  output logic [K:0]         dvld_o
);
  localparam int CW = W * W;
  localparam int NV = 2 * K - 2;
  localparam logic [W-1:0] ZERO_OH = W'(1);

  function automatic logic [2*W-1:0] shift_chain(input logic [W-1:0] start,
                                                 input logic [CW-1:0] bits);
    logic [W-1:0] r;
    logic [CW-1:0] d;
    logic [W-1:0] dd;
    r = start;
    d = '0;
    for (int j = 0; j < CW; j++) begin
      d[j] = bits[j] & r[W-1];
      if (bits[j]) r = {r[W-2:0], r[W-1]};
    end
    for (int g = 0; g < W; g++) dd[g] = |d[g*W +: W];
    return {dd, r};
  endfunction

  function automatic logic [W-2:0] therm(input logic [W-1:0] oh);
    logic [W-2:0] t;
    t = '0;
    for (int j = 0; j < W - 1; j++)
      for (int m = j + 1; m < W; m++)
        t[j] = t[j] | oh[m];
    return t;
  endfunction

  logic [NV:1] vsr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vsr <= '0;
    else        vsr <= {vsr[NV-1:1], in_valid};

  for (genvar h = 2; h <= K; h++) begin : g_lvl
    localparam int NC = W ** (K - h);
    logic [W-1:0] dg   [NC][h];
    logic [W-1:0] cy   [NC][h-1];
    logic         tp   [NC];
    logic [W-1:0] dg_n [NC][h];
    logic [W-1:0] cy_n [NC][h-1];
    logic         tp_n [NC];

    if (h == 2) begin : g_leaf
      always_comb begin
        logic [W-1:0] cc;
        for (int c = 0; c < NC; c++) begin
          {cy_n[c][0], dg_n[c][0]} = shift_chain(ZERO_OH, in_bits[c*CW +: CW]);
          {cc, dg_n[c][1]} = shift_chain(ZERO_OH, CW'(cy[c][0]));
          tp_n[c] = |cc;
        end
      end
    end else begin : g_node
      logic tpd [NC*W];
      always_ff @(posedge clk or negedge rst_n)
        for (int q = 0; q < NC * W; q++)
          if (!rst_n) tpd[q] <= 1'b0;
          else        tpd[q] <= g_lvl[h-1].tp[q];

      always_comb begin
        logic [CW-1:0] cb;
        logic [W-1:0]  cc;
        for (int c = 0; c < NC; c++) begin
          for (int i = 1; i < h; i++) begin
            cb = '0;
            for (int s = 0; s < W; s++)
              cb[s*(W-1) +: W-1] = therm(g_lvl[h-1].dg[c*W+s][i-1]);
            if (i > 1) cb[W*(W-1) +: W] = cy[c][i-2];
            {cy_n[c][i-1], dg_n[c][i-1]} = shift_chain(ZERO_OH, cb);
          end
          cb = '0;
          for (int s = 0; s < W; s++) cb[s] = tpd[c*W+s];
          cb[W +: W] = cy[c][h-2];
          {cc, dg_n[c][h-1]} = shift_chain(ZERO_OH, cb);
          tp_n[c] = |cc;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n)
      for (int c = 0; c < NC; c++) begin
        if (!rst_n) begin
          tp[c] <= 1'b0;
          for (int i = 0; i < h; i++) dg[c][i] <= ZERO_OH;
          for (int i = 0; i < h - 1; i++) cy[c][i] <= '0;
        end else begin
          tp[c] <= tp_n[c];
          for (int i = 0; i < h; i++) dg[c][i] <= dg_n[c][i];
          for (int i = 0; i < h - 1; i++) cy[c][i] <= cy_n[c][i];
        end
      end
  end

  for (genvar i = 1; i <= K; i++) begin : g_out
    assign dig_o[(i-1)*W +: W] = g_lvl[K].dg[0][i-1];
    assign dvld_o[i-1]         = vsr[K+i-2];
  end
  assign top_o     = g_lvl[K].tp[0];
  assign dvld_o[K] = vsr[NV];
endmodule

module radix_popcount_chk #(
  parameter int W = 4,
  parameter int K = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [K*W-1:0] dig_o,
  input logic           top_o,
  input logic [K:0]     dvld_o
);
  for (genvar i = 0; i < K; i++) begin : g_dig
    // R2
    onehot_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dig_o[i*W +: W]) == 1);
  end

  for (genvar i = 1; i < K; i++) begin : g_stag
    // R4
    stagger_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dvld_o[i] == $past(dvld_o[i-1]));
  end

  // R5
  top_with_msd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dvld_o[K] == dvld_o[K-1]);

  // R5
  top_full_msd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dvld_o[K] && top_o) |-> dig_o[(K-1)*W +: W] == W'(1));

  // R5
  top_full_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dvld_o[K] && top_o) |-> $past(dig_o[(K-2)*W +: W]) == W'(1));
endmodule

bind radix_popcount radix_popcount_chk #(.W(W), .K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .dig_o(dig_o), .top_o(top_o), .dvld_o(dvld_o));

// File: tb/tb_radix_popcount.sv
`timescale 1ns/1ps
module tb_radix_popcount;
  localparam int W = 4;
  localparam int K = 3;
  localparam int N = W ** K;
  localparam int MAXS = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N-1:0] in_bits = '0;
  logic [K*W-1:0] dig_o;
  logic top_o;
  logic [K:0] dvld_o;

  always #4 clk = ~clk;

  radix_popcount #(.W(W), .K(K)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .dig_o(dig_o), .top_o(top_o), .dvld_o(dvld_o));

  int checks = 0;
  int fails = 0;
  int s = 0;
  logic vh [MAXS];
  int   ch [MAXS];

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s step %0d: actual=%b expected=%b", tag, s, act, exp);
    end
  endtask

  task automatic check_outs();
    for (int i = 1; i <= K; i++) begin
      int p = s - (K + i - 2);
      logic ev = (p >= 0) ? vh[p] : 1'b0;
      chk("R4/R7 digit valid", W'(dvld_o[i-1]), W'(ev));
      if (ev) chk("R3/R6/R8 digit", dig_o[(i-1)*W +: W],
                  W'(1) << ((ch[p] / (W ** (i - 1))) % W));
    end
    begin
      int p = s - (2 * K - 2);
      logic ev = (p >= 0) ? vh[p] : 1'b0;
      chk("R5/R7 top valid", W'(dvld_o[K]), W'(ev));
      if (ev) chk("R5 top", W'(top_o), W'(ch[p] == N));
    end
  endtask

  task automatic step(input logic v, input logic [N-1:0] b);
    @(negedge clk);
    check_outs();
    in_valid = v;
    in_bits = b;
    vh[s] = v;
    ch[s] = $countones(b);
    s++;
  endtask

  function automatic logic [N-1:0] fill(input int c);
    logic [N-1:0] b = '0;
    for (int j = 0; j < c; j++) b[j] = 1'b1;
    return b;
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R6 watchdog: actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 valid", W'(dvld_o), '0);
    chk("R1 top", W'(top_o), '0);
    for (int i = 0; i < K; i++) chk("R1 digit", dig_o[i*W +: W], W'(1));

    step(1'b1, '0);
    step(1'b1, '1);
    step(1'b1, '0);
    step(1'b1, '1);
    step(1'b0, '1);   // R7 invalid all-ones word
    step(1'b0, fill(5));
    step(1'b1, fill(1));
    foreach (ch[q]) if (q < 0) ch[q] = 0;
    // R8 carry boundaries
    for (int c = 0; c <= N; c++) begin
      step(1'b1, fill(c));
      step(1'b1, fill(c) << (N - c));
    end
    // R6 back-to-back overlap
    for (int r = 0; r < 8; r++) begin
      step(1'b1, '1);
      step(1'b1, fill(W * W - 1));
      step(1'b1, '0);
      step(1'b1, fill(N - 1));
    end
    for (int r = 0; r < 1500; r++) begin
      logic [N-1:0] b;
      int mode = $urandom % 3;
      for (int j = 0; j < N; j++)
        b[j] = (mode == 0) ? 1'($urandom % 2) :
               (mode == 1) ? 1'(($urandom % 16) != 0) : 1'(($urandom % 16) == 0);
      step(1'(($urandom % 4) != 0), b);
    end
    for (int r = 0; r < 2 * K; r++) step(1'b0, '0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule